// File: doc/BRIEF.md
# TDM Serial Time-Slot Port

This block links a serial time-division-multiplexed voice/data bus to a byte-wide parallel side. A frame on the serial bus holds a programmable number of 8-bit slots, from 1 to 128. Two independent 128-bit enable masks choose which slots the block receives and which it drives. The enabled slots may be scattered anywhere in the frame. Each received byte from an enabled slot leaves on a valid/ready stream with its slot number attached. For each enabled transmit slot, the block takes one byte from an input stream and shifts it onto the serial line.

The serial bit clock, the serial data and the frame sync arrive as plain pins. The block synchronises them into the system clock domain and acts on the detected edges of the bit clock. Data changes after a falling edge of the bit clock and is sampled on the rising edge, MSB first. The frame boundary has two possible sources. In internal mode the block counts bits against the programmed slot count and drives its own one-bit frame-sync pulse. In external mode a pulse on the frame-sync input realigns the counters.

A consumer that is not ready when a byte arrives loses that byte, and a sticky overrun flag is set. A transmit slot with no byte waiting sends all ones, and a sticky underrun flag is set. Both flags clear only on reset.

Top module: `tdm_port`

## Requirements
- R1: After reset: sd_oe_o=0, sd_o=0, fs_o=0, rx_valid_o=0, tx_ready_o=0, overrun_o=0 and underrun_o=0.
- R2: In internal mode (cfg_ext_fs_i=0), fs_o is high for exactly the bit period of bit 0 of slot 0 and low for every other bit. The frame is (cfg_last_slot_i+1)*8 bit clocks long.
- R3: In external mode (cfg_ext_fs_i=1), the bit sampled while fs_i is high becomes bit 0 of slot 0, wherever the counters stood before. fs_o stays low in this mode.
- R4: For a slot whose bit s in rx_mask_i is 1, the 8 bits sampled on sclk_i rising edges are put together MSB first. They are presented for one clock cycle on rx_data_o, with rx_slot_o = s. A slot whose mask bit is 0 yields no byte.
- R5: During a slot whose bit in tx_mask_i is 1, sd_oe_o is 1 and the byte is shifted out MSB first, changing after sclk_i falling edges. During any other slot, sd_oe_o=0 and sd_o=0.
- R6: Each enabled transmit slot takes exactly one byte, through a one-cycle tx_ready_o pulse. Bytes go out in the order the stream supplies them.
- R7: If tx_valid_i is low when an enabled transmit slot starts, that slot carries 8'hFF and underrun_o is set and stays set until reset.
- R8: If rx_ready_i is low in the cycle rx_valid_o is high, the byte is dropped, never presented again, and overrun_o is set until reset.
- R9: Frame lengths at both ends of the range, 1 slot (cfg_last_slot_i=0) and 128 slots (cfg_last_slot_i=127), work for receive, transmit and frame-sync timing.
- R10: In internal mode, pulses on fs_i have no effect on slot timing, received bytes or transmitted bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ext_fs_i | input | 1 | 1: frame sync taken from fs_i; 0: generated internally |
| cfg_last_slot_i | input | 7 | Number of slots per frame minus one |
| rx_mask_i | input | 128 | Receive enable, one bit per slot |
| tx_mask_i | input | 128 | Transmit enable, one bit per slot |
| sclk_i | input | 1 | Serial bit clock (idles high) |
| fs_i | input | 1 | External frame-sync pulse |
| sd_i | input | 1 | Serial receive data |
| fs_o | output | 1 | Generated frame-sync pulse |
| sd_o | output | 1 | Serial transmit data |
| sd_oe_o | output | 1 | Output enable for sd_o |
| rx_data_o | output | 8 | Received byte |
| rx_slot_o | output | 7 | Slot number of the received byte |
| rx_valid_o | output | 1 | Received byte present (one cycle) |
| rx_ready_i | input | 1 | Consumer can accept the received byte |
| tx_data_i | input | 8 | Byte for the next enabled transmit slot |
| tx_valid_i | input | 1 | tx_data_i holds a byte |
| tx_ready_o | output | 1 | Byte taken this cycle |
| overrun_o | output | 1 | Sticky: a received byte was dropped |
| underrun_o | output | 1 | Sticky: a transmit slot was filled with 8'hFF |

## Verification
The bench aims at scattered masks with gaps between enabled slots. A design that tied slot numbers to a running count of enabled slots would report wrong slot tags or shift bytes into the wrong slots. It runs the single-slot and full 128-slot frames, where an off-by-one in the wrap would stretch or shorten the frame and move the frame-sync pulse. In external mode it inserts stray bits before the first pulse to catch a design that ignores realignment. It also pulses fs_i in internal mode to catch one that lets the pin disturb the counters. Empty transmit queues and a stalled consumer check that underrun sends all ones, and that a dropped byte neither reappears later nor goes unflagged.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_IDX_W = 3;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/tdm_sync.sv
`timescale 1ns/1ps
module tdm_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else stage_q[g] <= stage_q[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tdm_frame.sv
`timescale 1ns/1ps
module tdm_frame
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS_MAX = 128,
  localparam int unsigned SLOT_W = $clog2(SLOTS_MAX),
  localparam int unsigned POS_W  = SLOT_W + BIT_IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 ext_fs_i,
  input  logic                 fs_i,
  input  logic [SLOT_W-1:0]    last_slot_i,
  output logic [SLOT_W-1:0]    cur_slot_o,
  output logic [BIT_IDX_W-1:0] cur_bit_o,
  output logic [SLOT_W-1:0]    nxt_slot_o,
  output logic [BIT_IDX_W-1:0] nxt_bit_o,
  output logic                 fs_o
);
  logic [POS_W-1:0] pos_q, cur_pos, last_pos;
  logic             fs_q;

  assign last_pos = {last_slot_i, {BIT_IDX_W{1'b1}}};
  // external pulse forces this bit to be slot 0 bit 0
  assign cur_pos  = (ext_fs_i && fs_i) ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fs_q  <= 1'b0;
    end else begin
      if (rise_i) pos_q <= (cur_pos >= last_pos) ? '0 : cur_pos + 1'b1;
      if (fall_i) fs_q  <= !ext_fs_i && (pos_q == '0);
    end
  end

  assign cur_slot_o = cur_pos[POS_W-1:BIT_IDX_W];
  assign cur_bit_o  = cur_pos[BIT_IDX_W-1:0];
  assign nxt_slot_o = pos_q[POS_W-1:BIT_IDX_W];
  assign nxt_bit_o  = pos_q[BIT_IDX_W-1:0];
  assign fs_o       = fs_q;
endmodule

// File: rtl/tdm_rx.sv
`timescale 1ns/1ps
module tdm_rx
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS_MAX = 128,
  localparam int unsigned SLOT_W = $clog2(SLOTS_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rise_i,
  input  logic                 sd_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [BIT_IDX_W-1:0] bit_i,
  input  logic [SLOTS_MAX-1:0] mask_i,
  input  logic                 ready_i,
  output logic [BYTE_W-1:0]    data_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 valid_o,
  output logic                 overrun_o
);
  logic [BYTE_W-2:0] sh_q;
  logic              last_bit;

  assign last_bit = (bit_i == {BIT_IDX_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      data_o    <= '0;
      slot_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        sh_q <= {sh_q[BYTE_W-3:0], sd_i};
        if (last_bit && mask_i[slot_i]) begin
          data_o  <= {sh_q, sd_i};
          slot_o  <= slot_i;
          valid_o <= 1'b1;
        end
      end
      if (valid_o && !ready_i) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_tx.sv
`timescale 1ns/1ps
module tdm_tx
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS_MAX = 128,
  localparam int unsigned SLOT_W = $clog2(SLOTS_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fall_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [BIT_IDX_W-1:0] bit_i,
  input  logic [SLOTS_MAX-1:0] mask_i,
  input  logic [BYTE_W-1:0]    data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  output logic                 sd_o,
  output logic                 oe_o,
  output logic                 underrun_o
);
  logic [BYTE_W-2:0] sh_q;
  logic [BYTE_W-1:0] load_byte;
  logic              active, first_bit;

  assign active    = mask_i[slot_i];
  assign first_bit = (bit_i == '0);
  assign ready_o   = fall_i && active && first_bit;
  assign load_byte = valid_i ? data_i : FILL_BYTE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      sd_o       <= 1'b0;
      oe_o       <= 1'b0;
      underrun_o <= 1'b0;
    end else if (fall_i) begin
      if (!active) begin
        sd_o <= 1'b0;
        oe_o <= 1'b0;
      end else if (first_bit) begin
        sd_o <= load_byte[BYTE_W-1];
        sh_q <= load_byte[BYTE_W-2:0];
        oe_o <= 1'b1;
        if (!valid_i) underrun_o <= 1'b1;
      end else begin
        sd_o <= sh_q[BYTE_W-2];
        sh_q <= {sh_q[BYTE_W-3:0], 1'b0};
        oe_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_port.sv
`timescale 1ns/1ps
module tdm_port
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS_MAX   = 128,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SLOT_W = $clog2(SLOTS_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_ext_fs_i,
  input  logic [SLOT_W-1:0]    cfg_last_slot_i,
  input  logic [SLOTS_MAX-1:0] rx_mask_i,
  input  logic [SLOTS_MAX-1:0] tx_mask_i,
  input  logic                 sclk_i,
  input  logic                 fs_i,
  input  logic                 sd_i,
  output logic                 fs_o,
  output logic                 sd_o,
  output logic                 sd_oe_o,
  output logic [BYTE_W-1:0]    rx_data_o,
  output logic [SLOT_W-1:0]    rx_slot_o,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  input  logic [BYTE_W-1:0]    tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic                 overrun_o,
  output logic                 underrun_o
);
  logic [2:0]           pins_s;
  logic                 sclk_s, fs_s, sd_s, sclk_prev_q;
  logic                 rise, fall;
  logic [SLOT_W-1:0]    cur_slot, nxt_slot;
  logic [BIT_IDX_W-1:0] cur_bit, nxt_bit;

  // bit clock idles high: reset its stages to 1 so release makes no edge
  tdm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fs_i, sd_i, sclk_i}),
    .q_o   (pins_s)
  );
  assign {fs_s, sd_s, sclk_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b1;
    else         sclk_prev_q <= sclk_s;
  end
  assign rise = sclk_s && !sclk_prev_q;
  assign fall = !sclk_s && sclk_prev_q;

  tdm_frame #(.SLOTS_MAX(SLOTS_MAX)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .ext_fs_i   (cfg_ext_fs_i),
    .fs_i       (fs_s),
    .last_slot_i(cfg_last_slot_i),
    .cur_slot_o (cur_slot),
    .cur_bit_o  (cur_bit),
    .nxt_slot_o (nxt_slot),
    .nxt_bit_o  (nxt_bit),
    .fs_o       (fs_o)
  );

  tdm_rx #(.SLOTS_MAX(SLOTS_MAX)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .sd_i     (sd_s),
    .slot_i   (cur_slot),
    .bit_i    (cur_bit),
    .mask_i   (rx_mask_i),
    .ready_i  (rx_ready_i),
    .data_o   (rx_data_o),
    .slot_o   (rx_slot_o),
    .valid_o  (rx_valid_o),
    .overrun_o(overrun_o)
  );

  tdm_tx #(.SLOTS_MAX(SLOTS_MAX)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .slot_i    (nxt_slot),
    .bit_i     (nxt_bit),
    .mask_i    (tx_mask_i),
    .data_i    (tx_data_i),
    .valid_i   (tx_valid_i),
    .ready_o   (tx_ready_o),
    .sd_o      (sd_o),
    .oe_o      (sd_oe_o),
    .underrun_o(underrun_o)
  );
endmodule

// File: rtl/tdm_port_chk.sv
`timescale 1ns/1ps
module tdm_port_chk #(
  parameter int unsigned SLOTS_MAX = 128,
  localparam int unsigned SLOT_W = $clog2(SLOTS_MAX)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [SLOTS_MAX-1:0] rx_mask_i,
  input logic [SLOT_W-1:0]    rx_slot_o,
  input logic                 rx_valid_o,
  input logic                 rx_ready_i,
  input logic                 tx_valid_i,
  input logic                 tx_ready_o,
  input logic                 sd_o,
  input logic                 sd_oe_o,
  input logic                 overrun_o,
  input logic                 underrun_o
);
  assert_rx_in_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_mask_i[rx_slot_o]);
  assert_rx_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_quiet_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_oe_o |-> !sd_o);
  assert_ready_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> !tx_ready_o);
  assert_underrun_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> underrun_o);
  assert_underrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
  assert_overrun_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> overrun_o);
  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind tdm_port tdm_port_chk #(.SLOTS_MAX(SLOTS_MAX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_mask_i (rx_mask_i),
  .rx_slot_o (rx_slot_o),
  .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i),
  .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o),
  .sd_o      (sd_o),
  .sd_oe_o   (sd_oe_o),
  .overrun_o (overrun_o),
  .underrun_o(underrun_o)
);

// File: tb/sim_tdm_port.sv
`timescale 1ns/1ps
module sim_tdm_port;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext = 1'b0;
  logic [6:0]   last_slot = 7'd3;
  logic [127:0] rx_mask = '0;
  logic [127:0] tx_mask = '0;
  logic         sclk = 1'b1, fs_in = 1'b0, sd_in = 1'b0;
  logic         fs_o, sd_o, sd_oe;
  logic [7:0]   rx_data;
  logic [6:0]   rx_slot;
  logic         rx_valid, rx_ready = 1'b1;
  logic [7:0]   tx_data = '0;
  logic         tx_valid = 1'b0, tx_ready;
  logic         overrun, underrun;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [14:0] rxq [$];
  logic [7:0]  txq [$];
  logic [7:0]  txexp [$];

  always #10 clk = ~clk;

  tdm_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ext_fs_i(ext), .cfg_last_slot_i(last_slot),
    .rx_mask_i(rx_mask), .tx_mask_i(tx_mask), .sclk_i(sclk), .fs_i(fs_in), .sd_i(sd_in),
    .fs_o(fs_o), .sd_o(sd_o), .sd_oe_o(sd_oe), .rx_data_o(rx_data), .rx_slot_o(rx_slot),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .overrun_o(overrun), .underrun_o(underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_byte(input int seed, input int s);
    return 8'((seed * 7 + s * 37 + 1) & 255);
  endfunction

  task automatic push_tx(input logic [7:0] b);
    txq.push_back(b);
    txexp.push_back(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sclk = 1'b1; fs_in = 1'b0; sd_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic junk_bits(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (5) @(negedge clk);
      sclk = 1'b0; sd_in = i[0]; fs_in = 1'b0;
      repeat (5) @(negedge clk);
      sclk = 1'b1;
    end
  endtask

  // one frame on the serial bus; fs_extra: bit index of a stray fs_i pulse (-1: none)
  task automatic run_frame(input int seed, input int fs_extra, input bit rdy);
    int nslots;
    bit fs_bad, oe_bad;
    logic [7:0] rb, got, ex;
    nslots = int'(last_slot) + 1;
    fs_bad = 0; oe_bad = 0;
    rx_ready = rdy;
    for (int s = 0; s < nslots; s++) begin
      rb = rx_byte(seed, s);
      got = '0;
      for (int b = 0; b < 8; b++) begin
        repeat (5) @(negedge clk);
        sclk = 1'b0;
        sd_in = rb[7-b];
        fs_in = (ext && s == 0 && b == 0) || (s * 8 + b == fs_extra);
        repeat (5) @(negedge clk);
        if (fs_o !== (!ext && s == 0 && b == 0)) fs_bad = 1;
        if (tx_mask[s]) begin
          if (sd_oe !== 1'b1) oe_bad = 1;
          got = {got[6:0], sd_o};
        end else if (sd_oe !== 1'b0 || sd_o !== 1'b0) oe_bad = 1;
        sclk = 1'b1;
      end
      if (rx_mask[s] && rdy) rxq.push_back({7'(s), rb});
      if (tx_mask[s]) begin
        ex = (txexp.size() > 0) ? txexp.pop_front() : 8'hFF;
        check(got === ex, "R5/R6", $sformatf("tx byte slot %0d", s), got, ex);
      end
    end
    fs_in = 1'b0;
    check(!fs_bad, ext ? "R3" : "R2", "fs_o per-bit pattern", fs_bad, 0);
    check(!oe_bad, "R5", "sd_oe_o/sd_o on slots", oe_bad, 0);
  endtask

  task automatic drain_rx(input string req);
    repeat (10) @(negedge clk);
    check(rxq.size() == 0, req, "rx bytes missing", rxq.size(), 0);
    rxq.delete();
  endtask

  // rx monitor: pop and compare on every accepted byte
  initial begin
    logic [14:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid && rx_ready) begin
        if (rxq.size() == 0) begin
          check(0, "R4", "unexpected rx byte", {rx_slot, rx_data}, 0);
        end else begin
          e = rxq.pop_front();
          check({rx_slot, rx_data} === e, "R4", "rx slot/byte", {rx_slot, rx_data}, e);
        end
      end
    end
  end

  // tx stream driver
  initial begin
    bit pend;
    pend = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) pend = 0;
      if (pend) begin
        if (txq.size() > 0) void'(txq.pop_front());
        pend = 0;
      end
      tx_valid = (txq.size() > 0);
      tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
      if (tx_ready && tx_valid) pend = 1;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", "run timed out", 0, 1);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    check(sd_oe === 1'b0 && sd_o === 1'b0, "R1", "serial output idle", {sd_oe, sd_o}, 0);
    check(fs_o === 1'b0 && rx_valid === 1'b0 && tx_ready === 1'b0, "R1", "strobes low",
          {fs_o, rx_valid, tx_ready}, 0);
    check(overrun === 1'b0 && underrun === 1'b0, "R1", "flags clear", {overrun, underrun}, 0);

    // R2/R4/R5/R6: internal sync, 4 slots, scattered masks
    ext = 1'b0; last_slot = 7'd3;
    rx_mask = '0; rx_mask[0] = 1'b1; rx_mask[2] = 1'b1;
    tx_mask = '0; tx_mask[1] = 1'b1; tx_mask[3] = 1'b1;
    push_tx(8'hA5); push_tx(8'h3C); push_tx(8'h01); push_tx(8'h80);
    run_frame(1, -1, 1);
    // R10: stray fs_i pulse in internal mode
    run_frame(2, 20, 1);
    drain_rx("R4");
    check(underrun === 1'b0, "R7", "no underrun while fed", underrun, 0);
    check(overrun === 1'b0, "R8", "no overrun while ready", overrun, 0);

    // R7: empty transmit stream
    run_frame(3, -1, 1);
    drain_rx("R4");
    check(underrun === 1'b1, "R7", "underrun sticky", underrun, 1);

    // R8: stalled consumer, then fresh bytes only
    run_frame(4, -1, 0);
    repeat (10) @(negedge clk);
    check(overrun === 1'b1, "R8", "overrun sticky", overrun, 1);
    run_frame(5, -1, 1);
    drain_rx("R8");

    // R3: external sync with stray bits before the pulse
    do_reset();
    ext = 1'b1; last_slot = 7'd2;
    rx_mask = '0; rx_mask[0] = 1'b1; rx_mask[1] = 1'b1; rx_mask[2] = 1'b1;
    tx_mask = '0;
    junk_bits(3);
    run_frame(6, -1, 1);
    drain_rx("R3");
    tx_mask[0] = 1'b1; tx_mask[2] = 1'b1;
    push_tx(8'h5A); push_tx(8'hC3);
    run_frame(7, -1, 1);
    drain_rx("R3");
    check(underrun === 1'b0, "R3", "aligned tx fed", underrun, 0);

    // R9: single-slot frames
    do_reset();
    ext = 1'b0; last_slot = 7'd0;
    rx_mask = '0; rx_mask[0] = 1'b1;
    tx_mask = '0; tx_mask[0] = 1'b1;
    push_tx(8'h96); push_tx(8'h0F); push_tx(8'hE1);
    run_frame(8, -1, 1);
    run_frame(9, -1, 1);
    run_frame(10, -1, 1);
    drain_rx("R9");

    // R9: full 128-slot frame
    do_reset();
    last_slot = 7'd127;
    rx_mask = '0; rx_mask[0] = 1'b1; rx_mask[5] = 1'b1; rx_mask[127] = 1'b1;
    tx_mask = '0; tx_mask[64] = 1'b1; tx_mask[127] = 1'b1;
    push_tx(8'h77); push_tx(8'h12);
    run_frame(11, -1, 1);
    drain_rx("R9");
    check(underrun === 1'b0 && overrun === 1'b0, "R9", "flags after long frame",
          {underrun, overrun}, 0);

    finish_run();
  end
endmodule